// File: doc/BRIEF.md
# Linked-Ring Transmit DMA Engine

This block feeds packets to a MAC transmitter. It walks a circular chain of descriptors that sit in memory. Each descriptor takes 32 bytes. Its first word holds the address of the packet buffer, its second word is a config word and its third word points to the next descriptor. The rest is padding. In the config word, bit 31 flags the descriptor as empty, which means software owns it. Bits 11:0 give the packet length in bytes.

Software loads the address of the first descriptor, then sets the run bit. From then on the engine works through the ring without further help:

1. It reads the config word. If the empty flag is set, the engine clears its run bit and parks on that descriptor.
2. Otherwise it reads the buffer address and the next pointer.
3. It streams the packet out byte by byte on a valid/ready output.
4. It writes the config word back with the empty flag set, which returns the descriptor to software.
5. It counts the packet and moves to the next descriptor.

Software stops the engine by writing 0 to the run bit and polling until the bit reads 0.

Back-pressure on the byte stream follows valid/ready rules. A byte transfers on every clock edge where `tx_tvalid` and `tx_tready` are both high. While `tx_tready` is low, the engine holds `tx_tvalid`, `tx_tdata` and `tx_tlast` steady. The memory side uses a request/grant handshake. The engine holds the request and its address, write flag and write data until a grant arrives. Read data comes back on `mem_rvalid` on a later cycle. Only one read is ever outstanding.

Top module: `txring_dma`

## Requirements
- R1: After reset the run bit reads 0, the sent counter reads 0, and neither `tx_tvalid` nor `mem_req` is asserted.
- R2: A descriptor pointer write updates `cur_desc_o` only while the run bit is 0. While the engine runs, such a write is ignored.
- R3: Writing 1 on `ctl_run` starts the engine at the current descriptor. The engine first reads the config word at pointer+4. If bit 31 of that word is set, the engine clears the run bit and leaves the pointer on that descriptor. It emits no byte and writes no memory.
- R4: For a descriptor whose bit 31 is clear, the engine reads the buffer address at pointer+0. It then emits exactly the number of bytes given in config bits 11:0, taken from consecutive 32-bit words starting at that address. Within each word the least significant byte goes first. `tx_tlast` is high on the final byte only.
- R5: After the last byte is accepted, the engine writes the config word back to pointer+4 with bit 31 set and bits 30:0 unchanged. The write's grant increments the sent counter by exactly one.
- R6: After a write-back, the pointer takes the next-descriptor word read from pointer+8. The engine goes on through the ring, wrapping from the last descriptor to the first, until it meets an empty descriptor.
- R7: A descriptor of length 0 emits no bytes. It is still written back as empty and counted.
- R8: Writing 0 on `ctl_run` while the engine runs lets the current descriptor finish. The engine then fetches no further descriptor and clears the run bit.
- R9: While `tx_tvalid` is high and `tx_tready` is low, `tx_tvalid` stays high and `tx_tdata` and `tx_tlast` hold their values.
- R10: While `mem_req` is high and `mem_gnt` is low, `mem_req`, `mem_addr` and `mem_we` hold their values on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we | input | 1 | Write strobe for the run bit |
| ctl_run | input | 1 | Run bit value written with `ctl_we` |
| ptr_we | input | 1 | Write strobe for the descriptor pointer |
| ptr_wdata | input | 32 | Descriptor address to load |
| run_o | output | 1 | Run bit; drops when the engine halts |
| cur_desc_o | output | 32 | Address of the current descriptor |
| sent_cnt_o | output | 16 | Count of completed descriptors, wrapping |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| tx_tdata | output | 8 | Packet byte |
| tx_tvalid | output | 1 | Byte valid |
| tx_tready | input | 1 | Sink accepts the byte |
| tx_tlast | output | 1 | Final byte of the packet |

## Verification
The hardest situation to reach from the ports is a stop request that lands mid-packet while the next descriptor is already filled. A faulty engine would slip straight into that next packet. The bench fills two long descriptors and waits until the first byte of the first packet has been accepted. It then writes the run bit to 0 and expects only the first packet's bytes and write-back, with the second config word left untouched. The bench keeps random grant delays, read latencies and `tx_tready` stalls running throughout, so every hold rule is exercised across both word and packet boundaries.

// File: rtl/txr_pkg.sv
package txr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CFG_REQ, ST_CFG_WAIT, ST_BUF_REQ, ST_BUF_WAIT,
    ST_NXT_REQ, ST_NXT_WAIT, ST_DAT_REQ, ST_DAT_WAIT, ST_DAT_SEND, ST_WB_REQ
  } txr_state_e;

  // word offsets inside a descriptor
  localparam int unsigned OFS_BUF = 0;
  localparam int unsigned OFS_CFG = 4;
  localparam int unsigned OFS_NXT = 8;
  // ownership flag position in the config word
  localparam int unsigned OWN_BIT = 31;
endpackage

// File: rtl/txr_csr.sv
module txr_csr #(
  parameter int AW    = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             ctl_run,
  input  logic             ptr_we,
  input  logic [AW-1:0]    ptr_wdata,
  input  logic             halt,
  input  logic             pkt_done,
  input  logic [AW-1:0]    next_ptr,
  output logic             run,
  output logic             stop_req,
  output logic [AW-1:0]    cur_ptr,
  output logic [CNT_W-1:0] sent_cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      stop_req <= 1'b0;
      cur_ptr  <= '0;
      sent_cnt <= '0;
    end else begin
      if (halt) begin
        run      <= 1'b0;
        stop_req <= 1'b0;
      end
      if (ctl_we) begin
        if (ctl_run) begin
          run      <= 1'b1;
          stop_req <= 1'b0;
        end else if (run) begin
          stop_req <= 1'b1;
        end
      end
      if (pkt_done)            cur_ptr <= next_ptr;
      else if (ptr_we && !run) cur_ptr <= ptr_wdata;
      if (pkt_done) sent_cnt <= sent_cnt + 1'b1;
    end
  end

  AST_PTR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(pkt_done)) |-> (cur_ptr == $past(cur_ptr))); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sent_cnt != $past(sent_cnt)) |-> (sent_cnt == $past(sent_cnt) + 1'b1)); // R5
endmodule

// File: rtl/txr_ser.sv
module txr_ser #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  localparam int NB = WORD_W / BYTE_W,
  localparam int CW = $clog2(NB + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic [CW-1:0]     nbytes,
  input  logic              last,
  input  logic              tready,
  output logic [BYTE_W-1:0] tdata,
  output logic              tvalid,
  output logic              tlast,
  output logic              done
);
  logic [WORD_W-1:0] sh_q;
  logic [CW-1:0]     left_q;
  logic              last_q;
  logic              fire;

  assign tvalid = (left_q != '0);
  assign fire   = tvalid && tready;
  assign tdata  = sh_q[BYTE_W-1:0];
  assign tlast  = last_q && (left_q == CW'(1));
  assign done   = fire && (left_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      last_q <= 1'b0;
    end else if (load) begin
      sh_q   <= word;
      left_q <= nbytes;
      last_q <= last;
    end else if (fire) begin
      sh_q   <= sh_q >> BYTE_W;
      left_q <= left_q - 1'b1;
    end
  end

  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tvalid && !tready) |=> (tvalid && $stable(tdata) && $stable(tlast))); // R9
  AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    tlast |-> tvalid); // R4
endmodule

// File: rtl/txring_dma.sv
module txring_dma import txr_pkg::*; #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LEN_W = 12,
  parameter int CNT_W = 16,
  localparam int NB   = DW / 8,
  localparam int BW   = $clog2(NB + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             ctl_run,
  input  logic             ptr_we,
  input  logic [AW-1:0]    ptr_wdata,
  output logic             run_o,
  output logic [AW-1:0]    cur_desc_o,
  output logic [CNT_W-1:0] sent_cnt_o,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_gnt,
  input  logic             mem_rvalid,
  input  logic [DW-1:0]    mem_rdata,
  output logic [7:0]       tx_tdata,
  output logic             tx_tvalid,
  input  logic             tx_tready,
  output logic             tx_tlast
);
  txr_state_e     state;
  logic [DW-1:0]    cfg_q;
  logic [AW-1:0]    buf_q, nxt_q;
  logic [LEN_W-1:0] rem_q;
  logic [BW-1:0]    chunk;
  logic             run, stop_req, halt, pkt_done, ser_load, ser_done, final_chunk;
  logic [AW-1:0]    cur_ptr;

  txr_csr #(.AW(AW), .CNT_W(CNT_W)) u_csr (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_run(ctl_run),
    .ptr_we(ptr_we), .ptr_wdata(ptr_wdata), .halt(halt), .pkt_done(pkt_done),
    .next_ptr(nxt_q), .run(run), .stop_req(stop_req), .cur_ptr(cur_ptr),
    .sent_cnt(sent_cnt_o));

  txr_ser #(.WORD_W(DW), .BYTE_W(8)) u_ser (
    .clk(clk), .rst_n(rst_n), .load(ser_load), .word(mem_rdata), .nbytes(chunk),
    .last(final_chunk), .tready(tx_tready), .tdata(tx_tdata), .tvalid(tx_tvalid),
    .tlast(tx_tlast), .done(ser_done));

  assign run_o       = run;
  assign cur_desc_o  = cur_ptr;
  assign final_chunk = (rem_q <= LEN_W'(NB));
  assign chunk       = final_chunk ? rem_q[BW-1:0] : BW'(NB);
  assign ser_load    = (state == ST_DAT_WAIT) && mem_rvalid;
  assign pkt_done    = (state == ST_WB_REQ) && mem_gnt;
  assign halt        = ((state == ST_IDLE) && run && stop_req) ||
                       ((state == ST_CFG_WAIT) && mem_rvalid && mem_rdata[OWN_BIT]);

  always_comb begin
    mem_req   = state inside {ST_CFG_REQ, ST_BUF_REQ, ST_NXT_REQ, ST_DAT_REQ, ST_WB_REQ};
    mem_we    = (state == ST_WB_REQ);
    mem_wdata = cfg_q | (DW'(1) << OWN_BIT);
    case (state)
      ST_CFG_REQ, ST_WB_REQ: mem_addr = cur_ptr + AW'(OFS_CFG);
      ST_BUF_REQ:            mem_addr = cur_ptr + AW'(OFS_BUF);
      ST_NXT_REQ:            mem_addr = cur_ptr + AW'(OFS_NXT);
      ST_DAT_REQ:            mem_addr = buf_q;
      default:               mem_addr = cur_ptr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cfg_q <= '0;
      buf_q <= '0;
      nxt_q <= '0;
      rem_q <= '0;
    end else begin
      case (state)
        ST_IDLE:     if (run && !stop_req) state <= ST_CFG_REQ;
        ST_CFG_REQ:  if (mem_gnt) state <= ST_CFG_WAIT;
        ST_CFG_WAIT: if (mem_rvalid) begin
          cfg_q <= mem_rdata;
          state <= mem_rdata[OWN_BIT] ? ST_IDLE : ST_BUF_REQ;
        end
        ST_BUF_REQ:  if (mem_gnt) state <= ST_BUF_WAIT;
        ST_BUF_WAIT: if (mem_rvalid) begin
          buf_q <= mem_rdata;
          state <= ST_NXT_REQ;
        end
        ST_NXT_REQ:  if (mem_gnt) state <= ST_NXT_WAIT;
        ST_NXT_WAIT: if (mem_rvalid) begin
          nxt_q <= mem_rdata;
          rem_q <= cfg_q[LEN_W-1:0];
          state <= (cfg_q[LEN_W-1:0] == '0) ? ST_WB_REQ : ST_DAT_REQ;
        end
        ST_DAT_REQ:  if (mem_gnt) state <= ST_DAT_WAIT;
        ST_DAT_WAIT: if (mem_rvalid) state <= ST_DAT_SEND;
        ST_DAT_SEND: if (ser_done) begin
          rem_q <= rem_q - {{(LEN_W-BW){1'b0}}, chunk};
          buf_q <= buf_q + AW'(NB);
          state <= final_chunk ? ST_WB_REQ : ST_DAT_REQ;
        end
        ST_WB_REQ:   if (mem_gnt) state <= ST_IDLE;
        default:     state <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !tx_tvalid); // R3
  AST_HALT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_o) |-> (!tx_tvalid && !mem_req)); // R8
endmodule

// File: tb/sim_txring_dma.sv
module sim_txring_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0, ctl_run = 1'b0, ptr_we = 1'b0;
  logic [31:0] ptr_wdata = '0;
  logic        run_o;
  logic [31:0] cur_desc_o;
  logic [15:0] sent_cnt_o;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [7:0]  tx_tdata;
  logic        tx_tvalid, tx_tlast;
  logic        tx_tready = 1'b0;

  always #10 clk = ~clk;

  txring_dma u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_run(ctl_run), .ptr_we(ptr_we),
    .ptr_wdata(ptr_wdata), .run_o(run_o), .cur_desc_o(cur_desc_o), .sent_cnt_o(sent_cnt_o),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .tx_tdata(tx_tdata), .tx_tvalid(tx_tvalid), .tx_tready(tx_tready), .tx_tlast(tx_tlast));

  int checks = 0;
  int errors = 0;
  int bytes_seen = 0;
  logic [31:0] mem [int unsigned];
  logic [8:0]  exp_bytes [$];
  logic [63:0] exp_wr [$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] dsc(input int i);
    return 32'h1000 + 32'(i) * 32;
  endfunction
  function automatic logic [31:0] bfa(input int i);
    return 32'h4000 + 32'(i) * 32'h100;
  endfunction

  task automatic set_desc(input int i, input int len, input bit empty);
    mem[dsc(i)]     = bfa(i);
    mem[dsc(i) + 4] = {empty, 19'd0, 12'(len)};
    mem[dsc(i) + 8] = dsc((i + 1) % 4);
    for (int w = 0; w < 16; w++) mem[bfa(i) + 32'(w) * 4] = $urandom;
  endtask

  // reference: bytes a descriptor must produce and the write-back it must issue
  task automatic expect_desc(input int i);
    logic [31:0] cfg;
    int len;
    cfg = mem[dsc(i) + 4];
    len = int'(cfg[11:0]);
    for (int k = 0; k < len; k++) begin
      logic [31:0] w;
      w = mem[bfa(i) + 32'(k / 4) * 4];
      exp_bytes.push_back({(k == len - 1), w[8*(k%4) +: 8]});
    end
    exp_wr.push_back({dsc(i) + 32'd4, cfg | 32'h8000_0000});
  endtask

  // memory and sink model, driven away from the active edge
  int rd_delay = -1;
  logic [31:0] rd_pend;
  bit req_stall = 0, str_stall = 0;
  logic [31:0] stall_addr;
  logic [8:0]  stall_byte;
  always @(negedge clk) begin
    if (rst_n) begin
      if (req_stall)
        chk(mem_req && mem_addr == stall_addr, "R10 request held under no grant", {31'd0, mem_req, mem_addr}, {32'd1, stall_addr});
      if (str_stall)
        chk(tx_tvalid && {tx_tlast, tx_tdata} == stall_byte, "R9 byte held under stall", {tx_tvalid, tx_tlast, tx_tdata}, {1'b1, stall_byte});
      mem_rvalid = 1'b0;
      if (rd_delay == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = rd_pend;
        rd_delay   = -1;
      end else if (rd_delay > 0) begin
        rd_delay--;
      end
      mem_gnt = mem_req && rd_delay < 0 && !mem_rvalid && ($urandom_range(0, 3) != 0);
      if (mem_gnt) begin
        if (mem_we) begin
          if (exp_wr.size() == 0) begin
            chk(0, "R5 unexpected write-back", {mem_addr, mem_wdata}, 64'd0);
          end else begin
            logic [63:0] e;
            e = exp_wr.pop_front();
            chk({mem_addr, mem_wdata} == e, "R5 write-back address and data", {mem_addr, mem_wdata}, e);
          end
          mem[mem_addr] = mem_wdata;
        end else begin
          rd_pend  = mem.exists(mem_addr) ? mem[mem_addr] : 32'd0;
          rd_delay = $urandom_range(0, 2);
        end
      end
      req_stall  = mem_req && !mem_gnt;
      stall_addr = mem_addr;
      tx_tready  = ($urandom_range(0, 2) != 0);
      if (tx_tvalid && tx_tready) begin
        bytes_seen++;
        if (exp_bytes.size() == 0) begin
          chk(0, "R4 unexpected byte", {tx_tlast, tx_tdata}, 9'd0);
        end else begin
          logic [8:0] e;
          e = exp_bytes.pop_front();
          chk({tx_tlast, tx_tdata} == e, "R4 byte and last flag", {tx_tlast, tx_tdata}, e);
        end
      end
      str_stall  = tx_tvalid && !tx_tready;
      stall_byte = {tx_tlast, tx_tdata};
    end
  end

  task automatic write_ptr(input logic [31:0] a);
    @(negedge clk); ptr_we = 1'b1; ptr_wdata = a;
    @(negedge clk); ptr_we = 1'b0;
  endtask
  task automatic write_ctl(input bit b);
    @(negedge clk); ctl_we = 1'b1; ctl_run = b;
    @(negedge clk); ctl_we = 1'b0;
  endtask
  task automatic wait_halt();
    while (run_o) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask
  task automatic queues_drained(input string tag);
    chk(exp_bytes.size() == 0, tag, exp_bytes.size(), 0);
    chk(exp_wr.size() == 0, tag, exp_wr.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    chk(run_o == 0, "R1 run after reset", run_o, 0);
    chk(sent_cnt_o == 0, "R1 count after reset", sent_cnt_o, 0);
    chk(!tx_tvalid && !mem_req, "R1 outputs quiet in reset", {tx_tvalid, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_tvalid && !mem_req && !run_o, "R1 quiet after reset", {tx_tvalid, mem_req, run_o}, 0);

    set_desc(0, 5, 0); set_desc(1, 1, 0); set_desc(2, 13, 0); set_desc(3, 7, 1);

    // R3: start on an empty descriptor
    write_ptr(dsc(3));
    chk(cur_desc_o == dsc(3), "R2 pointer load while stopped", cur_desc_o, dsc(3));
    seen = bytes_seen;
    write_ctl(1);
    wait_halt();
    chk(sent_cnt_o == 0, "R3 empty descriptor not counted", sent_cnt_o, 0);
    chk(cur_desc_o == dsc(3), "R3 parks on empty descriptor", cur_desc_o, dsc(3));
    chk(bytes_seen == seen, "R3 no bytes from empty descriptor", bytes_seen, seen);
    chk(mem[dsc(3) + 4] == {1'b1, 19'd0, 12'd7}, "R3 empty config untouched", mem[dsc(3) + 4], {1'b1, 19'd0, 12'd7});

    // R4 R5 R6: three packets, halt on the fourth
    write_ptr(dsc(0));
    expect_desc(0); expect_desc(1); expect_desc(2);
    write_ctl(1);
    wait_halt();
    chk(sent_cnt_o == 3, "R5 count after three packets", sent_cnt_o, 3);
    chk(cur_desc_o == dsc(3), "R6 pointer follows chain", cur_desc_o, dsc(3));
    chk(mem[dsc(0) + 4] == 32'h8000_0005, "R5 config write-back d0", mem[dsc(0) + 4], 32'h8000_0005);
    chk(mem[dsc(2) + 4] == 32'h8000_000D, "R5 config write-back d2", mem[dsc(2) + 4], 32'h8000_000D);
    queues_drained("R4 all bytes and write-backs seen");

    // R7 R6 R2: zero length, wrap to d0, pointer write while running ignored
    set_desc(3, 0, 0); set_desc(0, 8, 0);
    expect_desc(3); expect_desc(0);
    write_ctl(1);
    write_ptr(32'h5000);
    wait_halt();
    chk(sent_cnt_o == 5, "R7 zero-length still counted", sent_cnt_o, 5);
    chk(cur_desc_o == dsc(1), "R6 wrap then halt, R2 write ignored", cur_desc_o, dsc(1));
    chk(mem[dsc(3) + 4] == 32'h8000_0000, "R7 zero-length write-back", mem[dsc(3) + 4], 32'h8000_0000);
    queues_drained("R7 queues after wrap");

    // R8: stop mid-packet with the next descriptor filled
    set_desc(1, 40, 0); set_desc(2, 40, 0);
    expect_desc(1);
    seen = bytes_seen;
    write_ctl(1);
    while (bytes_seen == seen) @(negedge clk);
    write_ctl(0);
    chk(run_o == 1, "R8 run holds until packet ends", run_o, 1);
    wait_halt();
    chk(run_o == 0, "R8 run cleared after stop", run_o, 0);
    chk(sent_cnt_o == 6, "R8 only current packet completes", sent_cnt_o, 6);
    chk(cur_desc_o == dsc(2), "R8 pointer on next descriptor", cur_desc_o, dsc(2));
    chk(mem[dsc(2) + 4] == 32'd40, "R8 next descriptor untouched", mem[dsc(2) + 4], 32'd40);
    queues_drained("R8 queues after stop");

    // resume where it stopped
    expect_desc(2);
    write_ctl(1);
    wait_halt();
    chk(sent_cnt_o == 7, "R6 resume count", sent_cnt_o, 7);
    chk(cur_desc_o == dsc(3), "R6 resume pointer", cur_desc_o, dsc(3));
    queues_drained("R4 queues after resume");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule